// File: doc/BRIEF.md
# Capture-Based Period Trim Controller

This block estimates the error of a local oscillator against an external event whose period is known, for example a signal derived from the mains frequency. A free-running counter on the local clock supplies timestamps. The block records a timestamp on every rising edge of the event input, after that input passes through a two-flop synchronizer. The difference between two successive timestamps is the measured period, in local clock cycles.

The block compares each measured period with an expected count and a tolerance. If the period is too long, the local clock is running fast, so the 6-bit trim code steps down by one. If the period is too short, the clock is running slow, so the code steps up by one. Inside the window the code is held. The trim code drives an oscillator tuning input elsewhere. The measured period and a one-cycle valid strobe are also brought out.

Top module: `period_trim_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `trim_o` is 32, `period_o` is 0 and `valid_o` is 0.
- R2: `period_o` equals the number of clock cycles between two consecutive rising edges of `evt_i`. `valid_o` is high for exactly one cycle for each measurement.
- R3: The first rising edge of `evt_i` after reset, or after `en_i` goes high, only stores a timestamp. It raises no `valid_o` and leaves `trim_o` unchanged.
- R4: When a valid measurement is greater than `expect_i + tol_i`, `trim_o` decreases by one in the cycle after `valid_o`.
- R5: When a valid measurement plus `tol_i` is less than `expect_i`, `trim_o` increases by one in the cycle after `valid_o`.
- R6: A measurement from `expect_i - tol_i` to `expect_i + tol_i`, both ends included, leaves `trim_o` unchanged. Both limits are computed without overflow.
- R7: A wrap of the 16-bit timestamp counter between two captures does not affect the measured period, because the subtraction is taken modulo 2^16.
- R8: `trim_o` saturates: it stays at 0 when a decrease is called for at 0, and it stays at 63 when an increase is called for at 63.
- R9: While `en_i` is low, rising edges of `evt_i` cause no capture and no `valid_o`, and both `trim_o` and `period_o` keep their values.
- R10: A rising edge of `evt_i` first sampled high at clock edge k shows up as `valid_o` after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Measurement and trim enable |
| evt_i | input | 1 | Asynchronous event input of known period |
| expect_i | input | 16 | Expected period in clock cycles |
| tol_i | input | 16 | Allowed deviation in clock cycles |
| trim_o | output | 6 | Oscillator trim code |
| period_o | output | 16 | Last measured period |
| valid_o | output | 1 | One-cycle strobe for a new measurement |

## Verification
Directed periods sit exactly on the window edges and one cycle past them. These cases tell the inclusive hold window apart from a step up or a step down. Long runs of periods that are too long, and then too short, drive the code into both rails and hold it there. A disabled stretch followed by re-enabling tells ignored edges apart from the priming capture. Several hundred random periods spread around the expected count check the measured values and the steps against a bench model, and the run is long enough that the timestamp counter wraps between captures.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ptc_edge_sync.sv
module ptc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d[0] = async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_comb begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ptc_timebase.sv
module ptc_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] stamp_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign stamp_o = cnt_q;
endmodule

// File: rtl/ptc_capture.sv
module ptc_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] stamp_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] held_q,   held_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             primed_q, primed_d;
  logic             valid_q,  valid_d;
  logic             take;

  always_comb begin
    take     = en_i & rise_i;
    held_d   = held_q;
    period_d = period_q;
    primed_d = primed_q;
    valid_d  = 1'b0;
    if (!en_i) begin
      primed_d = 1'b0;
    end else if (take) begin
      held_d   = stamp_i;
      primed_d = 1'b1;
      if (primed_q) begin
        // modulo subtraction absorbs a counter wrap
        period_d = stamp_i - held_q;
        valid_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= '0;
      period_q <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      held_q   <= held_d;
      period_q <= period_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  assign period_o = period_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/ptc_trim_step.sv
module ptc_trim_step
  import ptc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TRIM_W   = 6,
  parameter int unsigned TRIM_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic [TRIM_W-1:0] trim_o
);
  localparam int unsigned EXT_W = CNT_W + 1;
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_MIN = '0;
  localparam logic [TRIM_W-1:0] TRIM_ONE = {{(TRIM_W-1){1'b0}}, 1'b1};
  localparam logic [TRIM_W-1:0] TRIM_INI = TRIM_W'(TRIM_RST);

  logic [EXT_W-1:0]  per_x, hi_lim, lo_sum, exp_x;
  step_e             step;
  logic [TRIM_W-1:0] trim_q, trim_d;

  always_comb begin
    per_x  = {1'b0, period_i};
    exp_x  = {1'b0, expect_i};
    hi_lim = exp_x + {1'b0, tol_i};
    lo_sum = per_x + {1'b0, tol_i};
    if (per_x > hi_lim)      step = STEP_DOWN;  // long period: clock fast
    else if (lo_sum < exp_x) step = STEP_UP;    // short period: clock slow
    else                     step = STEP_HOLD;
  end

  always_comb begin
    trim_d = trim_q;
    if (valid_i) begin
      unique case (step)
        STEP_DOWN: if (trim_q != TRIM_MIN) trim_d = trim_q - TRIM_ONE;
        STEP_UP:   if (trim_q != TRIM_MAX) trim_d = trim_q + TRIM_ONE;
        default:   trim_d = trim_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trim_q <= TRIM_INI;
    else         trim_q <= trim_d;
  end

  assign trim_o = trim_q;
endmodule

// File: rtl/period_trim_ctrl.sv
module period_trim_ctrl #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TRIM_W      = 6,
  parameter int unsigned TRIM_RST    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              valid_o
);
  logic             evt_rise;
  logic [CNT_W-1:0] stamp;

  ptc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (evt_i),
    .rise_o  (evt_rise)
  );

  ptc_timebase #(.CNT_W(CNT_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stamp_o (stamp)
  );

  ptc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .rise_i   (evt_rise),
    .stamp_i  (stamp),
    .period_o (period_o),
    .valid_o  (valid_o)
  );

  ptc_trim_step #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_o),
    .period_i (period_o),
    .expect_i (expect_i),
    .tol_i    (tol_i),
    .trim_o   (trim_o)
  );
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned TRIM_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [CNT_W-1:0]  expect_i,
  input logic [CNT_W-1:0]  tol_i,
  input logic [TRIM_W-1:0] trim_o,
  input logic [CNT_W-1:0]  period_o,
  input logic              valid_o
);
  logic [CNT_W:0] hi_lim, lo_sum;
  logic           too_long, too_short;

  assign hi_lim    = {1'b0, expect_i} + {1'b0, tol_i};
  assign lo_sum    = {1'b0, period_o} + {1'b0, tol_i};
  assign too_long  = {1'b0, period_o} > hi_lim;
  assign too_short = lo_sum < {1'b0, expect_i};

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  trim_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && too_long && trim_o != '0) |=> (trim_o == $past(trim_o) - 1'b1));

  // R5
  trim_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && too_short && trim_o != '1) |=> (trim_o == $past(trim_o) + 1'b1));

  // R6
  trim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o || (!too_long && !too_short)) |=> $stable(trim_o));

  // R8
  trim_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && too_long && trim_o == '0) |=> (trim_o == '0));

  // R8
  trim_ceil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && too_short && trim_o == '1) |=> (trim_o == '1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && $stable(period_o)));
endmodule

bind period_trim_ctrl ptc_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .expect_i (expect_i),
  .tol_i    (tol_i),
  .trim_o   (trim_o),
  .period_o (period_o),
  .valid_o  (valid_o)
);

// File: tb/period_trim_ctrl_test.sv
module period_trim_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i;
  logic        evt_i;
  logic [15:0] expect_i;
  logic [15:0] tol_i;
  logic [5:0]  trim_o;
  logic [15:0] period_o;
  logic        valid_o;

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;
  int valid_seen = 0;
  int model_trim = 32;
  int q_per[$];
  int q_cyc[$];
  int last_rise = 0;
  bit primed = 1'b0;
  bit trim_due = 1'b0;
  int trim_exp = 0;
  bit done = 1'b0;

  period_trim_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .evt_i(evt_i),
    .expect_i(expect_i), .tol_i(tol_i),
    .trim_o(trim_o), .period_o(period_o), .valid_o(valid_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int next_trim(int t, int per, int ex, int tl);
    if (per > ex + tl)      return (t == 0)  ? 0  : t - 1;
    else if (per + tl < ex) return (t == 63) ? 63 : t + 1;
    else                    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: period, latency and trim against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (trim_due) begin
        check(int'(trim_o) == trim_exp, "R4/R5/R6/R8 trim", trim_o, trim_exp);
        trim_due = 1'b0;
      end
      if (valid_o) begin
        valid_seen++;
        if (q_per.size() == 0) begin
          check(1'b0, "R3/R9 unexpected valid", 1, 0);
        end else begin
          int p, c;
          p = q_per.pop_front();
          c = q_cyc.pop_front();
          if ((c / 65536) != ((c - p) / 65536))
            check(int'(period_o) == p, "R7 wrapped period", period_o, p);
          else
            check(int'(period_o) == p, "R2 period", period_o, p);
          check(cyc == c + 3, "R10 latency", cyc, c + 3);
          model_trim = next_trim(model_trim, p, int'(expect_i), int'(tol_i));
          trim_exp = model_trim;
          trim_due = 1'b1;
        end
      end
    end
  end

  // one event period: rise now, next rise p cycles later
  task automatic send(int p);
    @(negedge clk_i);
    evt_i = 1'b1;
    if (en_i) begin
      if (primed) begin
        q_per.push_back(cyc - last_rise);
        q_cyc.push_back(cyc);
      end
      primed = 1'b1;
      last_rise = cyc;
    end
    repeat (p / 2) @(negedge clk_i);
    evt_i = 1'b0;
    repeat (p - p / 2 - 1) @(negedge clk_i);
  endtask

  task automatic drain;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic summary;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    check(1'b0, "watchdog", cyc, 190000);
    summary();
  end

  initial begin
    int t0, p0, v0;
    void'($urandom(32'd4711));
    rst_ni = 1'b0; en_i = 1'b0; evt_i = 1'b0;
    expect_i = 16'd250; tol_i = 16'd20;
    repeat (3) @(negedge clk_i);
    check(trim_o == 6'd32 && period_o == 0 && valid_o == 0, "R1 reset", trim_o, 32);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(trim_o == 6'd32 && period_o == 0 && valid_o == 0, "R1 after release", period_o, 0);
    en_i = 1'b1;

    // R3: first rise only primes
    v0 = valid_seen;
    send(250);
    check(valid_seen == v0 && trim_o == 6'd32, "R3 priming", valid_seen - v0, 0);
    // window edges: R6 hold, R4 one past high, R5 one past low
    send(270); send(271); send(230); send(229); send(250);
    send(100);
    drain();
    check(int'(trim_o) == model_trim, "R6 window edges", trim_o, model_trim);

    // R8 floor, then ceiling
    for (int i = 0; i < 40; i++) send(400);
    send(100);
    drain();
    check(trim_o == 6'd0, "R8 floor", trim_o, 0);
    for (int i = 0; i < 70; i++) send(120);
    send(250);
    drain();
    check(trim_o == 6'd63, "R8 ceiling", trim_o, 63);

    // R9 disabled: edges ignored, state held
    @(negedge clk_i);
    en_i = 1'b0; primed = 1'b0;
    t0 = trim_o; p0 = period_o; v0 = valid_seen;
    for (int i = 0; i < 5; i++) send(90);
    drain();
    check(int'(trim_o) == t0 && valid_seen == v0, "R9 trim held", trim_o, t0);
    check(int'(period_o) == p0, "R9 period held", period_o, p0);

    // R3 after re-enable
    en_i = 1'b1;
    v0 = valid_seen;
    send(300);
    check(valid_seen == v0, "R3 re-enable priming", valid_seen - v0, 0);

    // random periods around the target; long enough to wrap the counter (R7)
    for (int i = 0; i < 330; i++) send(150 + int'($urandom_range(200)));
    send(250);
    drain();
    check(q_per.size() == 0, "R2 all measured", q_per.size(), 0);
    summary();
  end
endmodule